// File: doc/BRIEF.md
# Majority-Vote Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a small table of per-branch outcome histories. Each history records the last three resolved outcomes of the branches that map to that slot, and the slot is chosen by low-order bits of the branch address. In the run-time learning mode the guess is "taken" when most of the recorded outcomes were taken.

A front end presents the fetch address on the lookup port and receives a combinational guess in the same cycle. The back end reports every resolved branch on the update port with its address and real direction, and the matching history shifts that direction in at the next clock edge.

A mode input lets the guess fall back to two simpler policies. The fixed policy always guesses not taken. The static policy follows a loop/backward hint supplied with the lookup. Learning continues in every mode.

Top module: `majvote_bpred`

## Requirements
- R1: With `mode` = 0 (learning), `pred_taken` is 1 exactly when at least two of the three outcome bits held in the slot selected by `lk_pc` are 1 (taken).
- R2: With `mode` = 1 (fixed), `pred_taken` is 0 whatever the history or the hint.
- R3: With `mode` = 2 (static), `pred_taken` equals `lk_loop`: a branch hinted as a loop/backward branch is guessed taken, and any other branch is guessed not taken.
- R4: With `mode` = 3 (unused code), `pred_taken` is 0.
- R5: At a clock edge with `upd_valid` = 1, the selected history shifts one place toward its top bit, the oldest outcome is dropped, and `upd_taken` enters at bit 0. Only the three newest outcomes affect the guess.
- R6: The slot is selected by address bits [5:2] on both ports. Addresses that agree in those bits share a slot, and an update to one slot leaves every other slot unchanged.
- R7: A clock edge with `rst` = 1 clears every history to 000 (all not taken).
- R8: When a lookup and an update select the same slot in the same cycle, the lookup returns the guess formed from the history as it stood before that update. The update is visible from the following cycle.
- R9: While `upd_valid` = 0, no history changes, whatever `upd_pc` and `upd_taken` carry.
- R10: Updates are recorded in every mode, so history gathered while a fallback policy is selected is used once learning mode is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy: 0 learning, 1 fixed not taken, 2 static by hint, 3 not taken |
| lk_pc | input | 32 | Fetch address to be predicted |
| lk_loop | input | 1 | Hint that the looked-up branch is a loop/backward branch |
| pred_taken | output | 1 | Guessed direction, 1 = taken (combinational) |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch, 1 = taken |

## Verification
The learning policy is tried with three-outcome sequences that hold exactly one, two and three taken bits. These sequences separate a true majority rule from "newest outcome wins" or "any taken" rules. A four-outcome sequence whose first outcome disagrees with the last three shows whether the oldest bit is really discarded. Lookups at aliasing and neighbouring addresses show the slot selection. A lookup that collides with an update in the same cycle distinguishes pre-update reads from forwarded ones. Learning under the fallback policies, followed by a return to learning mode, shows that history gathering never pauses.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        BP_LEARN  = 2'd0,
        BP_NEVER  = 2'd1,
        BP_STATIC = 2'd2,
        BP_RSVD   = 2'd3
    } bp_mode_e;

    // lowest address bit used to pick a slot (word-aligned branches)
    localparam int unsigned BP_IDX_LO = 2;

    typedef struct packed {
        logic valid;
        logic taken;
    } bp_outcome_t;

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned HIST_W = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  bp_pkg::bp_outcome_t             wr_req,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [HIST_W-1:0]               rd_hist,
    output logic [(1<<IDX_W)*HIST_W-1:0]    all_hist
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (wr_req.valid) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (wr_idx == IDX_W'(e)) begin
                    hist_q[e] <= {hist_q[e][HIST_W-2:0], wr_req.taken};
                end
            end
        end
    end

    // read sees the registered value, i.e. the state before any same-cycle write
    assign rd_hist  = hist_q[rd_idx];
    assign all_hist = hist_q;

endmodule

// File: rtl/bp_vote.sv
module bp_vote #(
    parameter int unsigned HIST_W = 3
) (
    input  logic [1:0]        mode,
    input  logic              loop_hint,
    input  logic [HIST_W-1:0] hist,
    output logic              taken
);
    import bp_pkg::*;

    localparam int unsigned CNT_W  = $clog2(HIST_W + 1);
    localparam int unsigned NEEDED = (HIST_W + 1) / 2;

    logic [CNT_W-1:0] ones;
    logic             majority;

    always_comb begin
        ones = '0;
        for (int b = 0; b < HIST_W; b++) begin
            ones = ones + CNT_W'(hist[b]);
        end
    end

    assign majority = (ones >= CNT_W'(NEEDED));

    always_comb begin
        case (bp_mode_e'(mode))
            BP_LEARN:  taken = majority;
            BP_STATIC: taken = loop_hint;
            BP_NEVER:  taken = 1'b0;
            default:   taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/majvote_bpred.sv
module majvote_bpred #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned HIST_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_loop,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    import bp_pkg::*;

    localparam int unsigned DEPTH  = 1 << IDX_W;
    localparam int unsigned IDX_HI = BP_IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0]          lk_idx;
    logic [IDX_W-1:0]          upd_idx;
    logic [HIST_W-1:0]         lk_hist;
    logic [DEPTH*HIST_W-1:0]   hist_flat;
    bp_outcome_t               outcome;

    assign lk_idx        = lk_pc[IDX_HI:BP_IDX_LO];
    assign upd_idx       = upd_pc[IDX_HI:BP_IDX_LO];
    assign outcome.valid = upd_valid;
    assign outcome.taken = upd_taken;

    bp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (outcome),
        .wr_idx   (upd_idx),
        .rd_idx   (lk_idx),
        .rd_hist  (lk_hist),
        .all_hist (hist_flat)
    );

    bp_vote #(.HIST_W(HIST_W)) u_vote (
        .mode      (mode),
        .loop_hint (lk_loop),
        .hist      (lk_hist),
        .taken     (pred_taken)
    );

endmodule

// File: rtl/majvote_bpred_chk.sv
module majvote_bpred_chk #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned HIST_W = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic [1:0]                    mode,
    input logic [PC_W-1:0]               lk_pc,
    input logic                          lk_loop,
    input logic                          pred_taken,
    input logic                          upd_valid,
    input logic [PC_W-1:0]               upd_pc,
    input logic                          upd_taken,
    input logic [(1<<IDX_W)*HIST_W-1:0]  hist_flat
);
    localparam int unsigned LO = 2;
    localparam int unsigned HI = LO + IDX_W - 1;

    logic [IDX_W-1:0]  u_idx, l_idx, prev_idx;
    logic [HIST_W-1:0] u_ent, l_ent, prev_exp;

    assign u_idx = upd_pc[HI:LO];
    assign l_idx = lk_pc[HI:LO];
    assign u_ent = hist_flat[u_idx*HIST_W +: HIST_W];
    assign l_ent = hist_flat[l_idx*HIST_W +: HIST_W];

    always_ff @(posedge clk) begin
        prev_idx <= u_idx;
        prev_exp <= {u_ent[HIST_W-2:0], upd_taken};
    end

    // R2: fixed policy never guesses taken
    assert_never_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |-> !pred_taken);

    // R3: static policy follows the hint
    assert_static_hint_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |-> (pred_taken == lk_loop));

    // R1: empty history never votes taken, full history always does
    assert_vote_bounds_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> ((l_ent == '0) ? !pred_taken :
                            ((&l_ent) ? pred_taken : 1'b1)));

    // R5: reported outcome lands at bit 0 of the selected slot
    assert_shift_in_R5: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> (hist_flat[prev_idx*HIST_W +: HIST_W] == prev_exp));

    // R9: no report, no change
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(hist_flat));

    // R7: reset clears the whole table
    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (hist_flat == '0));

endmodule

bind majvote_bpred majvote_bpred_chk #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (.*);

// File: tb/majvote_bpred_test.sv
`timescale 1ns/1ps
module majvote_bpred_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [31:0] lk_pc;
    logic        lk_loop;
    logic        pred_taken;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [2:0] mdl [16];

    always #2.5 clk = ~clk;

    majvote_bpred uut (
        .clk(clk), .rst(rst), .mode(mode), .lk_pc(lk_pc), .lk_loop(lk_loop),
        .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken)
    );

    function automatic logic expect_pred(input logic [1:0] m, input logic [31:0] pc,
                                         input logic hint);
        logic [2:0] h;
        h = mdl[pc[5:2]];
        case (m)
            2'd0:    return (32'(h[0]) + 32'(h[1]) + 32'(h[2])) >= 2;
            2'd2:    return hint;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // drive a lookup just after a falling edge and compare against the model
    task automatic look(input string req, input logic [1:0] m, input logic [31:0] pc,
                        input logic hint);
        mode = m; lk_pc = pc; lk_loop = hint;
        #1;
        check_bit(req, pred_taken, expect_pred(m, pc, hint));
    endtask

    task automatic report(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
        mdl[pc[5:2]] = {mdl[pc[5:2]][1:0], t};
    endtask

    task automatic t_reset;
        @(negedge clk);
        for (int i = 0; i < 16; i++) look("R7", 2'd0, 32'(i) << 2, 1'b1);
    endtask

    task automatic t_majority;
        report(32'h0C, 1'b1); report(32'h0C, 1'b1);                 // 011
        look("R1", 2'd0, 32'h0C, 1'b0);
        report(32'h14, 1'b1); report(32'h14, 1'b0); report(32'h14, 1'b1); // 101
        look("R1", 2'd0, 32'h14, 1'b0);
        report(32'h18, 1'b1); report(32'h18, 1'b0); report(32'h18, 1'b0); // 100
        look("R1", 2'd0, 32'h18, 1'b1);
        report(32'h1C, 1'b1); report(32'h1C, 1'b1); report(32'h1C, 1'b1); // 111
        look("R1", 2'd0, 32'h1C, 1'b0);
    endtask

    task automatic t_shift;
        report(32'h20, 1'b1); report(32'h20, 1'b0);
        report(32'h20, 1'b0); report(32'h20, 1'b0);                 // T dropped
        look("R5", 2'd0, 32'h20, 1'b0);
        check_bit("R5", pred_taken, 1'b0);
        report(32'h24, 1'b0); report(32'h24, 1'b1);
        report(32'h24, 1'b1); report(32'h24, 1'b0);                 // 110
        look("R5", 2'd0, 32'h24, 1'b0);
        check_bit("R5", pred_taken, 1'b1);
    endtask

    task automatic t_index;
        look("R6", 2'd0, 32'hABCD_000F, 1'b0);                      // aliases slot 3
        check_bit("R6", pred_taken, 1'b1);
        look("R6", 2'd0, 32'h10, 1'b0);                             // neighbour slot 4
        check_bit("R6", pred_taken, 1'b0);
        look("R6", 2'd0, 32'h08, 1'b0);                             // neighbour slot 2
        check_bit("R6", pred_taken, 1'b0);
    endtask

    task automatic t_fallback;
        look("R2", 2'd1, 32'h1C, 1'b1);
        look("R2", 2'd1, 32'h0C, 1'b0);
        look("R3", 2'd2, 32'h30, 1'b1);
        look("R3", 2'd2, 32'h1C, 1'b0);
        look("R4", 2'd3, 32'h1C, 1'b1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        upd_valid = 1'b0; upd_pc = 32'h28; upd_taken = 1'b1;
        repeat (4) @(negedge clk);
        look("R9", 2'd0, 32'h28, 1'b0);
        check_bit("R9", pred_taken, 1'b0);
        upd_pc = 32'h1C; upd_taken = 1'b0;
        repeat (4) @(negedge clk);
        look("R9", 2'd0, 32'h1C, 1'b0);
        check_bit("R9", pred_taken, 1'b1);
    endtask

    task automatic t_collide;
        report(32'h2C, 1'b1);                                       // 001
        @(negedge clk);
        mode = 2'd0; lk_pc = 32'h2C; lk_loop = 1'b0;
        upd_valid = 1'b1; upd_pc = 32'h2C; upd_taken = 1'b1;
        #1;
        check_bit("R8", pred_taken, 1'b0);                          // old 001
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        mdl[11] = 3'b011;
        check_bit("R8", pred_taken, 1'b1);                          // new 011
    endtask

    task automatic t_learn_in_fallback;
        mode = 2'd1;
        report(32'h34, 1'b1); report(32'h34, 1'b1);
        look("R10", 2'd1, 32'h34, 1'b1);
        mode = 2'd2;
        report(32'h38, 1'b1); report(32'h38, 1'b1);
        look("R10", 2'd0, 32'h34, 1'b0);
        check_bit("R10", pred_taken, 1'b1);
        look("R10", 2'd0, 32'h38, 1'b0);
        check_bit("R10", pred_taken, 1'b1);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) mdl[i] = 3'b000;
        look("R7", 2'd0, 32'h1C, 1'b1);
        check_bit("R7", pred_taken, 1'b0);
        look("R7", 2'd0, 32'h34, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 3'b000;
        rst = 1'b1; mode = 2'd0; lk_pc = '0; lk_loop = 1'b0;
        upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_majority();
        t_shift();
        t_index();
        t_fallback();
        t_idle();
        t_collide();
        t_learn_in_fallback();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule